// File: doc/BRIEF.md
# Channel activity LED controller

This block keeps up to four per-channel status LEDs current. The LEDs sit on an external LED driver chip that is reached over I2C. Each channel reports a link-up level, receive and transmit activity pulses, and two controller-mode events: "entered reset mode" and "entered normal mode". From these inputs the block keeps a desired 8-bit LED-select word that holds one 2-bit code per channel. It also keeps a cached copy of the last word the chip accepted. It issues a register write to the driver chip only when the two differ.

After reset the block programs the driver chip with a fixed five-write sequence: two blink prescalers, two duty cycles, then the initial LED word. While at least one channel is up, a periodic tick re-evaluates every channel. The tick shows "on" for a channel that is down, slow blink for an idle channel that is up, and fast blink for a channel that saw traffic. A shutdown request turns the first two LEDs off and then silences the block. Each write is handed to an external bit-level I2C master as a (register, data) pair with a request/done/error handshake.

Top module: `chan_led_ctrl`

## Requirements
- R1: Channel c owns bits [2c+1:2c] of the LED-select word. The codes are 0 = on, 1 = off, 2 = slow blink, 3 = fast blink.
- R2: After reset, five writes go out in this order: (1, 44), (2, 0x80), (3, 8), (4, 0x80), (5, 0x40). The LED-select word lives in register 5.
- R3: An error on any start-up write ends the sequence. No request is ever raised again until the next reset.
- R4: `wr_req` stays high, with `wr_reg` and `wr_data` stable, until `wr_done` or `wr_err` is seen. `wr_req` drops in the following cycle, and at least one idle cycle separates two requests. `wr_req` is low during reset.
- R5: Register 5 is written only when the desired word differs from the cache. The cache takes the written value only on `wr_done`. After `wr_err`, the same word is attempted again.
- R6: A reset-mode event sets that channel's field to 0. A normal-mode event sets it to 2 and starts the tick timer if the timer is not already pending. If both events hit the same channel in the same cycle, the reset-mode event wins.
- R7: On a tick, each channel that is down gets 0. Each channel that is up gets 3 if it saw activity since the previous tick, otherwise 2. Mode events in the tick cycle override the tick result for their own channels.
- R8: After a tick, the timer re-arms only if some channel is up, or if a normal-mode event arrives in that same cycle. Otherwise ticks stop until the next normal-mode event.
- R9: A tick occurs TICK_CYCLES cycles after the timer is armed, and then every TICK_CYCLES cycles while it stays armed.
- R10: After `shut_req`, and after any write already in flight completes, register 5 is written with 0x05 (channels 0 and 1 off). The write is skipped if the cache already holds 0x05. After that, no further requests are raised and all events are ignored.
- R11: `wr_addr` always carries the 7-bit driver address 0x62. Each write is a (register, data) pair.
- R12: Activity is held in a per-channel sticky flag that the tick clears. A pulse in the tick cycle itself counts toward the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | NUM_CH | Per-channel interface-up level |
| rx_pulse | input | NUM_CH | Per-channel receive activity pulse |
| tx_pulse | input | NUM_CH | Per-channel transmit activity pulse |
| mode_reset | input | NUM_CH | Pulse: channel controller put into reset mode |
| mode_normal | input | NUM_CH | Pulse: channel controller put into normal mode |
| shut_req | input | 1 | Pulse: switch LEDs off and stop |
| wr_req | output | 1 | Write request to the I2C master |
| wr_addr | output | 7 | 7-bit target address of the LED driver |
| wr_reg | output | 8 | Register offset of the write |
| wr_data | output | 8 | Data byte of the write |
| wr_done | input | 1 | One-cycle pulse: write completed |
| wr_err | input | 1 | One-cycle pulse: write failed |

## Verification
A corrupted cache shows at the ports within two cycles of the write port going idle. It appears either as a spurious register-5 write or as a missing one, and the cycle-level reference comparison catches both. A wrong tick counter or pending flag moves the next fast/slow/on write away from its expected cycle, or makes it appear after all links went down. A lost or stuck activity flag shows up as code 3 where code 2 was expected, or the reverse, at the next tick. Error-retry, start-up abort and shutdown silence are checked against a log of every completed write.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;

    localparam int WORD_W    = 8;
    localparam int INIT_LEN  = 5;
    localparam int IDX_W     = 3;
    localparam int BLINK_REF = 44;

    typedef enum logic [1:0] {
        LED_ON   = 2'd0,
        LED_OFF  = 2'd1,
        LED_SLOW = 2'd2,
        LED_FAST = 2'd3
    } led_code_e;

    typedef enum logic [2:0] {
        SQ_INIT,
        SQ_RUN,
        SQ_SHUT,
        SQ_OFF,
        SQ_DEAD
    } seq_state_e;

    typedef struct packed {
        logic [7:0]        reg_ofs;
        logic [WORD_W-1:0] data;
    } wr_cmd_t;

    localparam logic [7:0] LED_REG = 8'd5;

    function automatic logic [WORD_W-1:0] put_field(input logic [WORD_W-1:0] w,
                                                    input int ch,
                                                    input led_code_e code);
        logic [WORD_W-1:0] r;
        r = w;
        r[2*ch +: 2] = code;
        return r;
    endfunction

    localparam logic [WORD_W-1:0] INIT_WORD = put_field(8'h00, 3, LED_OFF);
    localparam logic [WORD_W-1:0] OFF_WORD  = put_field(put_field(8'h00, 0, LED_OFF), 1, LED_OFF);

    function automatic wr_cmd_t init_cmd(input logic [IDX_W-1:0] idx);
        wr_cmd_t c;
        case (idx)
            3'd0:    c = '{reg_ofs: 8'd1, data: 8'(BLINK_REF)};
            3'd1:    c = '{reg_ofs: 8'd2, data: 8'h80};
            3'd2:    c = '{reg_ofs: 8'd3, data: 8'(BLINK_REF / 5)};
            3'd3:    c = '{reg_ofs: 8'd4, data: 8'h80};
            default: c = '{reg_ofs: LED_REG, data: INIT_WORD};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/led_tick_timer.sv
module led_tick_timer #(
    parameter int TICK_CYCLES = 125_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic arm,
    input  logic keep,
    output logic tick
);
    localparam int CW = $clog2(TICK_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(TICK_CYCLES - 1);

    logic          pend;
    logic [CW-1:0] cnt;

    assign tick = active && pend && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (tick) begin
            pend <= keep || arm;
            cnt  <= RELOAD;
        end else if (pend) begin
            cnt  <= cnt - 1'b1;
        end else if (arm) begin
            pend <= 1'b1;
            cnt  <= RELOAD;
        end
    end

    p_tick_gap_r9: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !keep && !arm) |=> !tick);

endmodule

// File: rtl/led_word_update.sv
module led_word_update
    import led_ctrl_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              tick,
    input  logic [NUM_CH-1:0] link_up,
    input  logic [NUM_CH-1:0] rx_pulse,
    input  logic [NUM_CH-1:0] tx_pulse,
    input  logic [NUM_CH-1:0] mode_reset,
    input  logic [NUM_CH-1:0] mode_normal,
    output logic [WORD_W-1:0] desired
);
    logic [NUM_CH-1:0] seen;
    logic [WORD_W-1:0] next_word;

    always_comb begin
        next_word = desired;
        if (tick) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (!link_up[c])
                    next_word = put_field(next_word, c, LED_ON);
                else if (seen[c])
                    next_word = put_field(next_word, c, LED_FAST);
                else
                    next_word = put_field(next_word, c, LED_SLOW);
            end
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (mode_reset[c])
                next_word = put_field(next_word, c, LED_ON);
            else if (mode_normal[c])
                next_word = put_field(next_word, c, LED_SLOW);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            desired <= INIT_WORD;
            seen    <= '0;
        end else begin
            seen <= (tick ? '0 : seen) | rx_pulse | tx_pulse;
            if (active)
                desired <= next_word;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_rst_on_r6: assert property (@(posedge clk) disable iff (rst)
            (active && mode_reset[c]) |=> desired[2*c +: 2] == 2'(LED_ON));
        p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
            (!tick && !mode_reset[c] && !mode_normal[c]) |=> $stable(desired[2*c +: 2]));
    end

endmodule

// File: rtl/led_write_seq.sv
module led_write_seq
    import led_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] desired,
    input  logic              shut_req,
    input  logic              wr_done,
    input  logic              wr_err,
    output logic              wr_req,
    output logic [7:0]        wr_reg,
    output logic [WORD_W-1:0] wr_data,
    output logic              active
);
    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic              req;
    wr_cmd_t           cmd;
    logic [WORD_W-1:0] cache;
    logic              shut_pend;

    assign active  = (state == SQ_INIT) || (state == SQ_RUN);
    assign wr_req  = req;
    assign wr_reg  = cmd.reg_ofs;
    assign wr_data = cmd.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_INIT;
            idx       <= '0;
            req       <= 1'b0;
            cmd       <= '0;
            cache     <= '0;
            shut_pend <= 1'b0;
        end else begin
            if (active && shut_req)
                shut_pend <= 1'b1;
            if (req) begin
                if (wr_done || wr_err) begin
                    req <= 1'b0;
                    if (wr_done && cmd.reg_ofs == LED_REG)
                        cache <= cmd.data;
                    case (state)
                        SQ_INIT: begin
                            if (wr_err)
                                state <= SQ_DEAD;
                            else if (idx == IDX_W'(INIT_LEN - 1))
                                state <= SQ_RUN;
                            else
                                idx <= idx + 1'b1;
                        end
                        SQ_SHUT: state <= SQ_OFF;
                        default: ;
                    endcase
                end
            end else begin
                case (state)
                    SQ_INIT: begin
                        req <= 1'b1;
                        cmd <= init_cmd(idx);
                    end
                    SQ_RUN: begin
                        if (shut_pend) begin
                            if (cache == OFF_WORD) begin
                                state <= SQ_OFF;
                            end else begin
                                req   <= 1'b1;
                                cmd   <= '{reg_ofs: LED_REG, data: OFF_WORD};
                                state <= SQ_SHUT;
                            end
                        end else if (desired != cache) begin
                            req <= 1'b1;
                            cmd <= '{reg_ofs: LED_REG, data: desired};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (req && !wr_done && !wr_err) |=> req && $stable(wr_reg) && $stable(wr_data));

    p_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (req && (wr_done || wr_err)) |=> !req);

    p_skip_same_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(req) && state == SQ_RUN) |-> wr_data != cache);

    p_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_OFF || state == SQ_DEAD) |-> !req);

    p_reg_range_r2: assert property (@(posedge clk) disable iff (rst)
        req |-> (wr_reg >= 8'd1 && wr_reg <= LED_REG));

endmodule

// File: rtl/chan_led_ctrl.sv
module chan_led_ctrl
    import led_ctrl_pkg::*;
#(
    parameter int         NUM_CH      = 4,
    parameter int         TICK_CYCLES = 125_000_000,
    parameter logic [6:0] DRV_ADDR    = 7'h62
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] link_up,
    input  logic [NUM_CH-1:0] rx_pulse,
    input  logic [NUM_CH-1:0] tx_pulse,
    input  logic [NUM_CH-1:0] mode_reset,
    input  logic [NUM_CH-1:0] mode_normal,
    input  logic              shut_req,
    output logic              wr_req,
    output logic [6:0]        wr_addr,
    output logic [7:0]        wr_reg,
    output logic [7:0]        wr_data,
    input  logic              wr_done,
    input  logic              wr_err
);
    logic              active;
    logic              tick;
    logic [WORD_W-1:0] desired;

    assign wr_addr = DRV_ADDR;

    led_tick_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .arm    (|mode_normal),
        .keep   (|link_up),
        .tick   (tick)
    );

    led_word_update #(.NUM_CH(NUM_CH)) u_word (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .tick        (tick),
        .link_up     (link_up),
        .rx_pulse    (rx_pulse),
        .tx_pulse    (tx_pulse),
        .mode_reset  (mode_reset),
        .mode_normal (mode_normal),
        .desired     (desired)
    );

    led_write_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .desired  (desired),
        .shut_req (shut_req),
        .wr_done  (wr_done),
        .wr_err   (wr_err),
        .wr_req   (wr_req),
        .wr_reg   (wr_reg),
        .wr_data  (wr_data),
        .active   (active)
    );

    p_addr_r11: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> wr_addr == 7'h62);

endmodule

// File: tb/sim_chan_led_ctrl.sv
module sim_chan_led_ctrl;
    localparam int NCH  = 4;
    localparam int TICK = 40;
    localparam int LAT  = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst;
    logic [NCH-1:0] link_up, rx_p, tx_p, m_rst, m_norm;
    logic           shut;
    logic           done, err;
    logic           wr_req;
    logic [6:0]     wr_addr;
    logic [7:0]     wr_reg, wr_data;

    chan_led_ctrl #(.NUM_CH(NCH), .TICK_CYCLES(TICK)) u0 (
        .clk(clk), .rst(rst), .link_up(link_up), .rx_pulse(rx_p), .tx_pulse(tx_p),
        .mode_reset(m_rst), .mode_normal(m_norm), .shut_req(shut),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_reg(wr_reg), .wr_data(wr_data),
        .wr_done(done), .wr_err(err)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int ms, midx, mreg, mdat, mcache, mdes, mcnt;
    bit mreq, mpend, mshut, started;
    bit [NCH-1:0] mact;
    int ireg [5] = '{1, 2, 3, 4, 5};
    int idat [5] = '{44, 128, 8, 128, 64};

    task automatic model_step();
        bit act_s, tk, oldshut;
        int d, code;
        act_s = (ms == 0 || ms == 1);
        tk    = act_s && mpend && mcnt == 0;
        d     = mdes;
        if (act_s) begin
            if (tk)
                for (int c = 0; c < NCH; c++) begin
                    code = !link_up[c] ? 0 : (mact[c] ? 3 : 2);
                    d = (d & ~(3 << (2*c))) | (code << (2*c));
                end
            for (int c = 0; c < NCH; c++) begin
                if (m_rst[c])       d = d & ~(3 << (2*c));
                else if (m_norm[c]) d = (d & ~(3 << (2*c))) | (2 << (2*c));
            end
        end
        if (!act_s) begin
            mpend = 0; mcnt = 0;
        end else if (tk) begin
            mpend = (|link_up) || (|m_norm); mcnt = TICK - 1;
        end else if (mpend) begin
            mcnt--;
        end else if (|m_norm) begin
            mpend = 1; mcnt = TICK - 1;
        end
        mact = (tk ? '0 : mact) | rx_p | tx_p;
        oldshut = mshut;
        if (act_s && shut) mshut = 1;
        if (mreq) begin
            if (done || err) begin
                mreq = 0;
                if (done && mreg == 5) mcache = mdat;
                if (ms == 0) begin
                    if (err) ms = 4;
                    else if (midx == 4) ms = 1;
                    else midx++;
                end else if (ms == 2) ms = 3;
            end
        end else if (ms == 0) begin
            mreq = 1; mreg = ireg[midx]; mdat = idat[midx];
        end else if (ms == 1) begin
            if (oldshut) begin
                if (mcache == 5) ms = 3;
                else begin mreq = 1; mreg = 5; mdat = 5; ms = 2; end
            end else if (mdes != mcache) begin
                mreq = 1; mreg = 5; mdat = mdes;
            end
        end
        if (act_s) mdes = d;
    endtask

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            ms = 0; midx = 0; mreq = 0; mreg = 0; mdat = 0; mcache = 0;
            mdes = 8'h40; mact = '0; mpend = 0; mcnt = 0; mshut = 0;
        end else begin
            model_step();
        end
    end

    // ---------------- per-cycle compare and I2C responder ----------------
    int lat = 0;
    int err_skip = -1;
    int n_log = 0;
    int log_reg [256];
    int log_dat [256];
    bit log_ok  [256];

    always @(negedge clk) begin
        if (started) begin
            check(wr_req === mreq, "R4 wr_req", int'(wr_req), int'(mreq));
            if (mreq) begin
                check(wr_reg === 8'(mreg), "R2 wr_reg", int'(wr_reg), mreg);
                check(wr_data === 8'(mdat), "R5 wr_data", int'(wr_data), mdat);
            end
            check(wr_addr === 7'h62, "R11 wr_addr", int'(wr_addr), 'h62);
        end
        if (rst) begin
            done = 0; err = 0; lat = 0;
        end else if (wr_req && !done && !err) begin
            if (lat == LAT) begin
                lat = 0;
                if (err_skip == 0) begin
                    err = 1; err_skip = -1;
                end else begin
                    if (err_skip > 0) err_skip--;
                    done = 1;
                end
                if (n_log < 256) begin
                    log_reg[n_log] = int'(wr_reg);
                    log_dat[n_log] = int'(wr_data);
                    log_ok[n_log]  = done;
                    n_log++;
                end
            end else begin
                lat++;
            end
        end else begin
            done = 0; err = 0;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL R4 watchdog actual=hang expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int last_dat();
        return (n_log > 0) ? log_dat[n_log-1] : -1;
    endfunction

    initial begin
        int base;
        rst = 1; link_up = '0; rx_p = '0; tx_p = '0; m_rst = '0; m_norm = '0;
        shut = 0; done = 0; err = 0;
        wait_n(3);
        check(wr_req === 1'b0, "R4 reset idle", int'(wr_req), 0);
        rst = 0;

        // start-up sequence
        wait_n(40);
        check(n_log == 5, "R2 init count", n_log, 5);
        for (int i = 0; i < 5; i++) begin
            check(log_reg[i] == ireg[i], "R2 init reg", log_reg[i], ireg[i]);
            check(log_dat[i] == idat[i], "R2 init data", log_dat[i], idat[i]);
        end

        // normal mode on channel 0 arms the timer
        m_norm[0] = 1; wait_n(1); m_norm[0] = 0;
        wait_n(10);
        check(last_dat() == 'h42, "R6 R1 slow field", last_dat(), 'h42);
        link_up[0] = 1; rx_p[0] = 1; wait_n(1); rx_p[0] = 0;
        base = n_log;
        wait_n(18);
        check(n_log == base, "R9 no early tick", n_log, base);
        wait_n(20);
        check(last_dat() == 'h03, "R7 R12 fast after activity", last_dat(), 'h03);
        wait_n(40);
        check(last_dat() == 'h02, "R7 slow when idle", last_dat(), 'h02);
        base = n_log;
        wait_n(40);
        check(n_log == base, "R5 unchanged word not written", n_log, base);
        link_up[0] = 0;
        wait_n(40);
        check(last_dat() == 'h00, "R7 on when down", last_dat(), 'h00);
        link_up[0] = 1; tx_p[0] = 1; wait_n(1); tx_p[0] = 0;
        base = n_log;
        wait_n(150);
        check(n_log == base, "R8 ticks stopped", n_log, base);
        link_up[0] = 0;

        // normal mode on channel 2, then tick with nothing up
        m_norm[2] = 1; wait_n(1); m_norm[2] = 0;
        wait_n(10);
        check(last_dat() == 'h20, "R6 channel 2 slow", last_dat(), 'h20);
        wait_n(45);
        check(last_dat() == 'h00, "R8 R7 final tick", last_dat(), 'h00);

        // reset-mode wins over normal-mode on the same channel
        base = n_log;
        m_rst[1] = 1; m_norm[1] = 1; wait_n(1); m_rst[1] = 0; m_norm[1] = 0;
        wait_n(60);
        check(n_log == base, "R6 reset wins", n_log, base);

        // error on a run-time write is retried
        err_skip = 0;
        base = n_log;
        m_norm[1] = 1; wait_n(1); m_norm[1] = 0;
        wait_n(15);
        check(n_log == base + 2, "R5 retry count", n_log, base + 2);
        check(log_ok[base] == 0 && log_dat[base] == 'h08, "R5 first attempt failed", log_dat[base], 'h08);
        check(log_ok[base+1] == 1 && log_dat[base+1] == 'h08, "R5 retry ok", log_dat[base+1], 'h08);

        // shutdown
        shut = 1; wait_n(1); shut = 0;
        wait_n(12);
        check(log_reg[n_log-1] == 5 && last_dat() == 'h05, "R10 off word", last_dat(), 'h05);
        base = n_log;
        m_norm[3] = 1; link_up = '1; wait_n(1); m_norm[3] = 0;
        wait_n(100);
        check(n_log == base, "R10 silent after shutdown", n_log, base);
        link_up = '0;

        // start-up aborted by an error on the second write
        rst = 1; err_skip = 1;
        wait_n(3);
        base = n_log;
        rst = 0;
        wait_n(60);
        check(n_log == base + 2, "R3 writes before abort", n_log, base + 2);
        check(log_reg[base] == 1 && log_ok[base] == 1, "R3 first write ok", log_reg[base], 1);
        check(log_ok[base+1] == 0, "R3 second write failed", int'(log_ok[base+1]), 0);
        m_norm[0] = 1; wait_n(1); m_norm[0] = 0;
        wait_n(60);
        check(n_log == base + 2, "R3 no activity after abort", n_log, base + 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule